// File: doc/BRIEF.md
# Committed-Rate Frame Policer

This block polices one virtual connection on a frame-based link. Each frame is announced by a one-cycle strobe that carries the frame's length in bits and its incoming discard-eligible (DE) flag. The block keeps a running count of the bits it has let through during the current measurement window. It compares that count, plus the new frame's length, against two limits: the committed burst and the committed burst plus the excess burst. From that comparison it gives a registered verdict one cycle later.

There are three outcomes. A frame that stays within the committed burst is forwarded, and its DE flag is left as it arrived. A frame that goes past the committed burst but stays within the excess allowance is forwarded with DE forced to 1. A frame that goes past both limits is dropped, and its bits are not counted. The window length is the committed burst divided by the committed rate. It is supplied already expressed in clock ticks. A down-counter marks the end of each window, and at that point the running count returns to zero.

Top module: `frame_rate_policer`

## Requirements
- R1: While reset is high and on the first cycle after it, `dec_valid` is 0, and the bit count starts from zero, so a frame of exactly the committed burst right after reset is conforming.
- R2: A frame for which running count plus length is at most the committed burst is conforming: `dec_pass`=1, `dec_de` equals the frame's incoming DE, `dec_cls`=2'b00.
- R3: A frame for which running count plus length is above the committed burst but at most committed plus excess is excess: `dec_pass`=1, `dec_de`=1, `dec_cls`=2'b01.
- R4: A frame for which running count plus length is above committed plus excess is violating: `dec_pass`=0, `dec_cls`=2'b10, and its length is not added to the running count.
- R5: The verdict appears on the cycle after the strobe (`dec_valid`=1 for exactly that cycle). `dec_valid` is 0 after any cycle without a strobe.
- R6: With window length T ticks, the running count is cleared on the T-th rising edge after reset release and on every T-th edge after that. A frame sampled on a clearing edge is judged against the old window's count, and its bits are discarded with that count.
- R7: A frame arriving with DE=1 leaves with `dec_de`=1 in every class.
- R8: Thresholds are inclusive. A sum exactly equal to a limit takes the better class, and a frame that crosses a limit takes the worse class as a whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tc_ticks | input | TC_W | Window length in clock ticks (at least 1) |
| cfg_commit_bits | input | BUR_W | Committed burst in bits |
| cfg_excess_bits | input | BUR_W | Excess burst in bits |
| frm_valid | input | 1 | One-cycle frame strobe |
| frm_len | input | LEN_W | Frame length in bits |
| frm_de_in | input | 1 | Incoming discard-eligible flag |
| dec_valid | output | 1 | Verdict valid |
| dec_pass | output | 1 | 1 = forward, 0 = drop |
| dec_de | output | 1 | Outgoing discard-eligible flag |
| dec_cls | output | 2 | 00 conform, 01 excess, 10 violate |

## Verification
The assertions assume that the three configuration inputs are held constant whenever reset is low and that the window length is never zero. The overflow bound on the running count depends on this. The bench therefore changes configuration only while reset is asserted, and it always programs a nonzero window. Strobes are single-cycle, and their lengths are chosen so that the expected sums land exactly on, just below and just above each limit.

// File: rtl/frp_pkg.sv
package frp_pkg;

    typedef enum logic [1:0] {
        CLS_CONFORM = 2'b00,
        CLS_EXCESS  = 2'b01,
        CLS_VIOLATE = 2'b10
    } frame_cls_e;

    typedef struct packed {
        logic       pass;
        logic       de;
        frame_cls_e cls;
    } verdict_t;

    function automatic verdict_t make_verdict(frame_cls_e c, logic de_in);
        verdict_t v;
        v.cls  = c;
        v.pass = (c != CLS_VIOLATE);
        v.de   = de_in | (c == CLS_EXCESS);
        return v;
    endfunction

endpackage

// File: rtl/frp_interval_timer.sv
module frp_interval_timer #(
    parameter int TC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TC_W-1:0] cfg_ticks,
    output logic            interval_end
);
    logic [TC_W-1:0] remain;

    assign interval_end = (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= cfg_ticks - TC_W'(1);
        end else if (interval_end) begin
            remain <= cfg_ticks - TC_W'(1);
        end else begin
            remain <= remain - TC_W'(1);
        end
    end
endmodule

// File: rtl/frp_bit_meter.sv
module frp_bit_meter #(
    parameter int ACC_W = 25,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             add_en,
    input  logic [LEN_W-1:0] add_len,
    output logic [ACC_W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
        end else if (add_en) begin
            acc <= acc + ACC_W'(add_len);
        end
    end
endmodule

// File: rtl/frp_classifier.sv
module frp_classifier
    import frp_pkg::*;
#(
    parameter int ACC_W = 25,
    parameter int LEN_W = 16,
    parameter int BUR_W = 24
) (
    input  logic [ACC_W-1:0] acc,
    input  logic [LEN_W-1:0] len,
    input  logic [BUR_W-1:0] commit_bits,
    input  logic [BUR_W-1:0] excess_bits,
    output frame_cls_e       cls
);
    localparam int SUM_W = ACC_W + 1;

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] lim_commit;
    logic [SUM_W-1:0] lim_total;

    always_comb begin
        sum        = SUM_W'(acc) + SUM_W'(len);
        lim_commit = SUM_W'(commit_bits);
        lim_total  = SUM_W'(commit_bits) + SUM_W'(excess_bits);
        if (sum <= lim_commit) begin
            cls = CLS_CONFORM;
        end else if (sum <= lim_total) begin
            cls = CLS_EXCESS;
        end else begin
            cls = CLS_VIOLATE;
        end
    end
endmodule

// File: rtl/frame_rate_policer.sv
module frame_rate_policer
    import frp_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int BUR_W = 24,
    parameter int TC_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TC_W-1:0]  cfg_tc_ticks,
    input  logic [BUR_W-1:0] cfg_commit_bits,
    input  logic [BUR_W-1:0] cfg_excess_bits,
    input  logic             frm_valid,
    input  logic [LEN_W-1:0] frm_len,
    input  logic             frm_de_in,
    output logic             dec_valid,
    output logic             dec_pass,
    output logic             dec_de,
    output logic [1:0]       dec_cls
);
    localparam int ACC_W = BUR_W + 1;

    logic             interval_end;
    logic [ACC_W-1:0] acc_bits;
    frame_cls_e       cls_now;
    verdict_t         verdict_now;
    verdict_t         verdict_q;
    logic             valid_q;
    logic             add_en;

    frp_interval_timer #(.TC_W(TC_W)) u_timer (
        .clk          (clk),
        .rst          (rst),
        .cfg_ticks    (cfg_tc_ticks),
        .interval_end (interval_end)
    );

    frp_classifier #(.ACC_W(ACC_W), .LEN_W(LEN_W), .BUR_W(BUR_W)) u_class (
        .acc         (acc_bits),
        .len         (frm_len),
        .commit_bits (cfg_commit_bits),
        .excess_bits (cfg_excess_bits),
        .cls         (cls_now)
    );

    assign verdict_now = make_verdict(cls_now, frm_de_in);
    assign add_en      = frm_valid && verdict_now.pass;

    frp_bit_meter #(.ACC_W(ACC_W), .LEN_W(LEN_W)) u_meter (
        .clk     (clk),
        .rst     (rst),
        .clear   (interval_end),
        .add_en  (add_en),
        .add_len (frm_len),
        .acc     (acc_bits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            verdict_q <= '0;
        end else begin
            valid_q <= frm_valid;
            if (frm_valid) begin
                verdict_q <= verdict_now;
            end
        end
    end

    assign dec_valid = valid_q;
    assign dec_pass  = verdict_q.pass;
    assign dec_de    = verdict_q.de;
    assign dec_cls   = verdict_q.cls;
endmodule

// File: rtl/frp_checker.sv
module frp_checker #(
    parameter int LEN_W = 16,
    parameter int BUR_W = 24,
    parameter int ACC_W = 25
) (
    input logic             clk,
    input logic             rst,
    input logic [BUR_W-1:0] cfg_commit_bits,
    input logic [BUR_W-1:0] cfg_excess_bits,
    input logic             frm_valid,
    input logic             frm_de_in,
    input logic             interval_end,
    input logic [ACC_W-1:0] acc_bits,
    input logic             dec_valid,
    input logic             dec_pass,
    input logic             dec_de,
    input logic [1:0]       dec_cls
);
    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> dec_valid); // R5
    AST_QUIET_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> !dec_valid); // R5
    AST_DE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_de_in) |=> dec_de); // R7
    AST_EXCESS_MARKED: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_cls == 2'b01) |-> (dec_pass && dec_de)); // R3
    AST_CONFORM_PASSES: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_cls == 2'b00) |-> dec_pass); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        acc_bits <= ACC_W'(cfg_commit_bits) + ACC_W'(cfg_excess_bits)); // R4
    AST_WINDOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        interval_end |=> (acc_bits == '0)); // R6
endmodule

bind frame_rate_policer frp_checker #(
    .LEN_W(LEN_W), .BUR_W(BUR_W), .ACC_W(ACC_W)
) u_frp_checker (
    .clk             (clk),
    .rst             (rst),
    .cfg_commit_bits (cfg_commit_bits),
    .cfg_excess_bits (cfg_excess_bits),
    .frm_valid       (frm_valid),
    .frm_de_in       (frm_de_in),
    .interval_end    (interval_end),
    .acc_bits        (acc_bits),
    .dec_valid       (dec_valid),
    .dec_pass        (dec_pass),
    .dec_de          (dec_de),
    .dec_cls         (dec_cls)
);

// File: tb/test_frame_rate_policer.sv
module test_frame_rate_policer;
    localparam int CLK_P = 10;
    localparam int LEN_W = 16;
    localparam int BUR_W = 24;
    localparam int TC_W  = 32;

    logic             clk;
    logic             rst;
    logic [TC_W-1:0]  cfg_tc_ticks;
    logic [BUR_W-1:0] cfg_commit_bits;
    logic [BUR_W-1:0] cfg_excess_bits;
    logic             frm_valid;
    logic [LEN_W-1:0] frm_len;
    logic             frm_de_in;
    logic             dec_valid;
    logic             dec_pass;
    logic             dec_de;
    logic [1:0]       dec_cls;

    int total = 0;
    int bad   = 0;

    frame_rate_policer #(.LEN_W(LEN_W), .BUR_W(BUR_W), .TC_W(TC_W)) i_frame_rate_policer (
        .clk             (clk),
        .rst             (rst),
        .cfg_tc_ticks    (cfg_tc_ticks),
        .cfg_commit_bits (cfg_commit_bits),
        .cfg_excess_bits (cfg_excess_bits),
        .frm_valid       (frm_valid),
        .frm_len         (frm_len),
        .frm_de_in       (frm_de_in),
        .dec_valid       (dec_valid),
        .dec_pass        (dec_pass),
        .dec_de          (dec_de),
        .dec_cls         (dec_cls)
    );

    initial clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got {valid,pass,de,cls}=%b expected %b", req, act, exp);
        end
    endtask

    task automatic do_reset(input int tc, input int bc, input int be);
        rst             = 1'b1;
        frm_valid       = 1'b0;
        frm_len         = '0;
        frm_de_in       = 1'b0;
        cfg_tc_ticks    = TC_W'(tc);
        cfg_commit_bits = BUR_W'(bc);
        cfg_excess_bits = BUR_W'(be);
        repeat (3) @(negedge clk);
        check("R1 valid low in reset", {dec_valid, 4'b0}, 5'b0);
        rst = 1'b0;
    endtask

    // drives a frame for one edge, then checks the verdict at the next negedge
    task automatic send(input string req, input int len, input logic de,
                        input logic e_pass, input logic e_de, input logic [1:0] e_cls);
        frm_valid = 1'b1;
        frm_len   = LEN_W'(len);
        frm_de_in = de;
        @(negedge clk);
        frm_valid = 1'b0;
        check(req, {dec_valid, dec_pass, dec_de, dec_cls}, {1'b1, e_pass, e_de, e_cls});
    endtask

    task automatic t_reset();
        do_reset(1000, 1000, 500);
        @(negedge clk);
        check("R1 valid low after reset", {dec_valid, 4'b0}, 5'b0);
        send("R1 count starts at zero", 1000, 1'b0, 1'b1, 1'b0, 2'b00);
        @(negedge clk);
        check("R5 valid drops after idle", {dec_valid, 4'b0}, 5'b0);
    endtask

    task automatic t_conform();
        do_reset(1000, 1000, 500);
        send("R2 conform", 400, 1'b0, 1'b1, 1'b0, 2'b00);
        send("R8 sum equals commit", 600, 1'b0, 1'b1, 1'b0, 2'b00);
        send("R8 one bit over commit", 1, 1'b0, 1'b1, 1'b1, 2'b01);
    endtask

    task automatic t_excess();
        do_reset(1000, 1000, 500);
        send("R3 excess", 1200, 1'b0, 1'b1, 1'b1, 2'b01);
        send("R8 sum equals commit plus excess", 300, 1'b0, 1'b1, 1'b1, 2'b01);
        send("R8 one bit over total", 1, 1'b0, 1'b0, 1'b0, 2'b10);
        send("R4 dropped bit not counted", 0, 1'b0, 1'b1, 1'b1, 2'b01);
    endtask

    task automatic t_violate();
        do_reset(1000, 1000, 500);
        send("R4 violate", 1600, 1'b0, 1'b0, 1'b0, 2'b10);
        send("R4 dropped frame not counted", 1000, 1'b0, 1'b1, 1'b0, 2'b00);
    endtask

    task automatic t_de_sticky();
        do_reset(1000, 1000, 500);
        send("R7 DE kept conform", 500, 1'b1, 1'b1, 1'b1, 2'b00);
        send("R7 DE kept excess", 700, 1'b1, 1'b1, 1'b1, 2'b01);
        send("R7 DE kept violate", 400, 1'b1, 1'b0, 1'b1, 2'b10);
    endtask

    task automatic t_interval();
        do_reset(10, 100, 50);
        send("R6 first frame edge 1", 100, 1'b0, 1'b1, 1'b0, 2'b00);
        repeat (8) @(negedge clk);
        send("R6 clearing edge uses old count", 1, 1'b0, 1'b1, 1'b1, 2'b01);
        send("R6 new window starts at zero", 100, 1'b0, 1'b1, 1'b0, 2'b00);
    endtask

    initial begin
        #(CLK_P * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_conform();
        t_excess();
        t_violate();
        t_de_sticky();
        t_interval();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule